// File: doc/BRIEF.md
# Smart Card Serial Status and Request Controller

This block holds the six status flags of a serial port running in smart card mode and turns them into three interrupt request levels and a two-bit priority vector. The transmit and receive engines report events as single-cycle strobes: a byte was accepted by the card, the card signalled an error, a byte arrived cleanly, a byte arrived with a parity error, or a byte arrived while the previous one was still unread. The flags are cleared by a DMA transfer acknowledge or by a CPU write.

The transmit request and the receive request are the lines a DMA engine is meant to use as triggers. The error request is meant for the CPU alone. When the card rejects a byte, the block asks the transmitter to resend the same byte and leaves the transmit-end flag low, so the DMA engine does not move the next byte early. No transmit-end interrupt exists in this mode.

Flag bits of `status`: bit 0 transmit empty, bit 1 transmit end, bit 2 receive full, bit 3 receive overrun, bit 4 receive parity error, bit 5 card error.

Top module: `sc_irq_ctrl`

## Requirements
- R1: After reset `status` is 6'b000011, `retx_req` is 0, and with both enables low all request outputs and `vec` are 0.
- R2: A `tx_done` strobe sets status bits 0 and 1 after the clock edge. `tx_req` is high while bit 0 is 1 and `tx_irq_en` is 1.
- R3: A `dma_tx_ack` strobe clears status bits 0 and 1. If `tx_done` comes in the same cycle, both bits end up 1.
- R4: A `tx_nack` strobe sets status bit 5, drives `retx_req` high for exactly the following cycle, and leaves bits 0 and 1 unchanged.
- R5: Status bit 5 is cleared only by a CPU clear. `err_req` is high when any of bits 3, 4 or 5 is 1 and `rx_irq_en` is 1, and it is low when `rx_irq_en` is 0.
- R6: A clean `rx_good` strobe sets status bit 2. `rx_req` is high while bit 2 and `rx_irq_en` are both 1. A `dma_rx_ack` strobe clears bit 2.
- R7: `rx_par_err` sets bit 4 and `rx_ovr_err` sets bit 3. If either comes together with `rx_good`, bit 2 is not set.
- R8: A `cpu_clr` bit clears its flag only if a `cpu_rd` strobe saw that flag as 1 after it was last set. A hardware set in the same cycle as the clear wins.
- R9: `vec` shows the highest-priority active request: 2'b01 for the error request, then 2'b10 for the receive request, then 2'b11 for the transmit request, and 2'b00 when none is active.
- R10: DMA acknowledges never change bits 3, 4 or 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_done | input | 1 | Byte sent and accepted by the card |
| tx_nack | input | 1 | Card signalled an error on the sent byte |
| rx_good | input | 1 | Byte received |
| rx_par_err | input | 1 | Received byte had a parity error |
| rx_ovr_err | input | 1 | Byte received while receive full was still set |
| dma_tx_ack | input | 1 | DMA wrote transmit data |
| dma_rx_ack | input | 1 | DMA read receive data |
| cpu_rd | input | 1 | CPU read of the status flags |
| cpu_clr | input | 6 | CPU clear mask, one bit per status flag |
| tx_irq_en | input | 1 | Transmit request enable |
| rx_irq_en | input | 1 | Receive and error request enable |
| status | output | 6 | Status flags |
| tx_req | output | 1 | Transmit request level (DMA capable) |
| rx_req | output | 1 | Receive request level (DMA capable) |
| err_req | output | 1 | Error request level (CPU only) |
| vec | output | 2 | Code of the highest-priority active request |
| retx_req | output | 1 | Resend strobe to the transmitter |

## Verification
The assertions check on every cycle the properties that hold from one cycle to the next: the resend strobe follows each card error, a card error never raises transmit end, the card error flag holds without a CPU clear, a receive error blocks receive full, DMA acknowledges clear the right flags, and the vector matches the request lines. Only the bench scenarios show the read-before-clear rule, set winning over clear, the enable gating of each request line, the reset values, and the order of priority when several requests are active at once.

// File: rtl/sc_irq_ctrl.sv
module sc_irq_ctrl #(
  parameter int NFLAG = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_done,
  input  logic             tx_nack,
  input  logic             rx_good,
  input  logic             rx_par_err,
  input  logic             rx_ovr_err,
  input  logic             dma_tx_ack,
  input  logic             dma_rx_ack,
  input  logic             cpu_rd,
  input  logic [NFLAG-1:0] cpu_clr,
  input  logic             tx_irq_en,
  input  logic             rx_irq_en,
  output logic [NFLAG-1:0] status,
  output logic             tx_req,
  output logic             rx_req,
  output logic             err_req,
  output logic [1:0]       vec,
  output logic             retx_req
);
  localparam int F_TXE = 0;
  localparam int F_TEND = 1;
  localparam int F_RXF = 2;
  localparam int F_OVR = 3;
  localparam int F_PAR = 4;
  localparam int F_CERR = 5;
  localparam logic [NFLAG-1:0] RST_VAL = NFLAG'((1 << F_TXE) | (1 << F_TEND));

  logic [NFLAG-1:0] seen, set_v, clr_hw, clr_cpu, status_n, seen_n;
  logic rx_bad;

  assign rx_bad = rx_par_err | rx_ovr_err;

  always_comb begin
    set_v = '0;
    set_v[F_TXE]  = tx_done;
    set_v[F_TEND] = tx_done;
    set_v[F_RXF]  = rx_good & ~rx_bad;
    set_v[F_OVR]  = rx_ovr_err;
    set_v[F_PAR]  = rx_par_err;
    set_v[F_CERR] = tx_nack;
    clr_hw = '0;
    clr_hw[F_TXE]  = dma_tx_ack;
    clr_hw[F_TEND] = dma_tx_ack;
    clr_hw[F_RXF]  = dma_rx_ack;
  end

  assign clr_cpu  = cpu_clr & seen;
  assign status_n = set_v | (status & ~(clr_hw | clr_cpu));
  assign seen_n   = (seen | (cpu_rd ? status : '0)) & status_n & ~set_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status   <= RST_VAL;
      seen     <= '0;
      retx_req <= 1'b0;
    end else begin
      status   <= status_n;
      seen     <= seen_n;
      retx_req <= tx_nack;
    end
  end

  assign tx_req  = status[F_TXE] & tx_irq_en;
  assign rx_req  = status[F_RXF] & rx_irq_en;
  assign err_req = (status[F_OVR] | status[F_PAR] | status[F_CERR]) & rx_irq_en;

  assign vec = err_req ? 2'b01 :
               rx_req  ? 2'b10 :
               tx_req  ? 2'b11 : 2'b00;
endmodule

module sc_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_done,
  input logic       tx_nack,
  input logic       rx_good,
  input logic       rx_par_err,
  input logic       rx_ovr_err,
  input logic       dma_tx_ack,
  input logic       dma_rx_ack,
  input logic [5:0] cpu_clr,
  input logic [5:0] status,
  input logic       tx_req,
  input logic       rx_req,
  input logic       err_req,
  input logic [1:0] vec,
  input logic       retx_req
);
  p_retx_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_nack |=> retx_req);
  p_retx_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_nack |=> !retx_req);
  p_nack_no_tend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_nack && !tx_done && !status[1]) |=> !status[1]);
  p_txack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_tx_ack && !tx_done) |=> (status[1:0] == 2'b00));
  p_cerr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status[5] && !cpu_clr[5]) |=> status[5]);
  p_rxerr_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_par_err || rx_ovr_err) && !status[2]) |=> !status[2]);
  p_rxgood_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_good && !rx_par_err && !rx_ovr_err) |=> status[2]);
  p_dma_keeps_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((dma_tx_ack || dma_rx_ack) && cpu_clr[5:3] == 3'b000) |=> $stable(status[5:3]) || $rose(|status[5:3]));
  p_vec_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_req |-> vec == 2'b01);
  p_vec_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (vec == 2'b00) |-> !(tx_req || rx_req || err_req));
endmodule

bind sc_irq_ctrl sc_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_done(tx_done), .tx_nack(tx_nack),
  .rx_good(rx_good), .rx_par_err(rx_par_err), .rx_ovr_err(rx_ovr_err),
  .dma_tx_ack(dma_tx_ack), .dma_rx_ack(dma_rx_ack), .cpu_clr(cpu_clr),
  .status(status), .tx_req(tx_req), .rx_req(rx_req), .err_req(err_req),
  .vec(vec), .retx_req(retx_req)
);

// File: tb/tb_sc_irq_ctrl.sv
module tb_sc_irq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_done = 0, tx_nack = 0, rx_good = 0, rx_par_err = 0, rx_ovr_err = 0;
  logic dma_tx_ack = 0, dma_rx_ack = 0, cpu_rd = 0;
  logic [5:0] cpu_clr = '0;
  logic tx_irq_en = 0, rx_irq_en = 0;
  logic [5:0] status;
  logic tx_req, rx_req, err_req, retx_req;
  logic [1:0] vec;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  sc_irq_ctrl dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    tx_done = 0; tx_nack = 0; rx_good = 0; rx_par_err = 0; rx_ovr_err = 0;
    dma_tx_ack = 0; dma_rx_ack = 0; cpu_rd = 0; cpu_clr = '0;
  endtask

  task automatic t_reset();
    chk("R1 status", status, 6'b000011);
    chk("R1 reqs", {tx_req, rx_req, err_req, retx_req}, 0);
    chk("R1 vec", vec, 0);
  endtask

  task automatic t_tx();
    tx_irq_en = 1; #0;
    chk("R2 tx_req on", tx_req, 1);
    chk("R9 vec tx", vec, 2'b11);
    dma_tx_ack = 1; tick();
    chk("R3 ack clears", status[1:0], 2'b00);
    chk("R3 tx_req off", tx_req, 0);
    tx_done = 1; tick();
    chk("R2 done sets", status[1:0], 2'b11);
    tx_done = 1; dma_tx_ack = 1; tick();
    chk("R3 set wins", status[1:0], 2'b11);
  endtask

  task automatic t_nack();
    dma_tx_ack = 1; tick();
    tx_nack = 1; tick();
    chk("R4 cerr set", status[5], 1);
    chk("R4 retx pulse", retx_req, 1);
    chk("R4 tx bits kept", status[1:0], 2'b00);
    tick();
    chk("R4 retx one cycle", retx_req, 0);
    chk("R5 gated off", err_req, 0);
    rx_irq_en = 1; #0;
    chk("R5 err_req", err_req, 1);
    chk("R9 vec err", vec, 2'b01);
    dma_tx_ack = 1; dma_rx_ack = 1; tick();
    chk("R10 dma keeps cerr", status[5], 1);
    cpu_clr = 6'b100000; tick();
    chk("R8 no clear unread", status[5], 1);
    cpu_rd = 1; tick();
    cpu_clr = 6'b100000; tick();
    chk("R5 cpu clear", status[5], 0);
    chk("R5 err_req off", err_req, 0);
  endtask

  task automatic t_rx();
    rx_good = 1; tick();
    chk("R6 rx full", status[2], 1);
    chk("R6 rx_req", rx_req, 1);
    chk("R9 vec rx", vec, 2'b10);
    dma_rx_ack = 1; tick();
    chk("R6 dma clears", status[2], 0);
  endtask

  task automatic t_rxerr();
    rx_good = 1; rx_par_err = 1; tick();
    chk("R7 no rx full", status[2], 0);
    chk("R7 par set", status[4], 1);
    rx_good = 1; rx_ovr_err = 1; tick();
    chk("R7 ovr set", status[4:2], 3'b110);
    rx_good = 1; tick();
    chk("R9 err over rx", vec, 2'b01);
    dma_rx_ack = 1; tick();
    chk("R10 dma keeps rx errs", status[4:3], 2'b11);
    cpu_rd = 1; tick();
    cpu_clr = 6'b011000; tick();
    chk("R8 read then clear", status[4:3], 2'b00);
  endtask

  task automatic t_setwins();
    rx_good = 1; tick();
    cpu_rd = 1; tick();
    cpu_clr = 6'b000100; rx_good = 1; tick();
    chk("R8 set beats clear", status[2], 1);
    cpu_clr = 6'b000100; tick();
    chk("R8 new set needs read", status[2], 1);
    cpu_rd = 1; tick();
    cpu_clr = 6'b000100; tick();
    chk("R8 clear after read", status[2], 0);
    rx_irq_en = 0; tx_irq_en = 0; #0;
    chk("R9 none", vec, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    t_reset();
    t_tx();
    t_nack();
    t_rx();
    t_rxerr();
    t_setwins();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule